// File: doc/BRIEF.md
# Paired Masked Watchpoint Comparator

This block watches a memory bus and raises a break request when an access matches a programmed pattern. It holds two comparator units. Each unit compares the observed address, data and eight control bits against stored values. A stored mask can turn any compared bit into a don't-care. Five of the control bits belong to the address group and three belong to the data group. A unit can also be made to depend on an external condition line.

Unit 1 can gate unit 0 in two ways. In the first way, a sticky flag records that unit 1 has hit at some earlier cycle, and unit 0 then needs that flag. In the second way, unit 0 needs unit 1's address-group comparison to be true in the same cycle. Either way, two comparators together describe one event, such as a bounded address window or an ordered pair of accesses.

Software programs the units through a small register file. A 5-bit register address is used: bits [4:3] pick the unit and bits [2:0] pick the register. A select strobe starts the access, and a write bit decides whether the access is a write or a read. All results are registered, so they appear one clock after the bus values that caused them.

Top module: `wpc_pair`

## Requirements
- R1: While reset is held, and in the first cycle after it, hit_o, range_o and brk_o are 0 and the chain flag is clear. Every register reads back as 0.
- R2: A unit hits when, for every compared bit, (stored value XNOR observed value) OR mask is 1. This covers 32 address bits, 32 data bits and 8 control bits. hit_o shows the result in the cycle after the bus values are sampled.
- R3: A mask bit of 1 makes the matching bit a don't-care. Changing a masked bit on the bus never changes hit_o or range_o.
- R4: Control bits [4:0] are part of the address group and control bits [7:5] are part of the data group. range_o[u] is 1 in the cycle after an enabled unit's address group matches, whatever the data group does. hit_o[u] implies range_o[u].
- R5: Config bit 3 (external-condition enable) makes unit u's hit also require ext_cond_i[u] = 1 in the sampled cycle.
- R6: With config bit 0 (enable) clear, a unit asserts neither hit_o nor range_o. This holds even when every mask bit is set.
- R7: With unit 0's config bit 1 (chain enable) set, unit 0 can hit only if the chain flag was already set before the sampled cycle. The chain flag sets on a unit 1 hit, so unit 0 can hit no earlier than one cycle after unit 1's hit is sampled.
- R8: The chain flag is sticky. Once set, it stays set until reset or until a write to unit 1's control value register (address 12). Such a write clears the flag even if unit 1 hits in the same cycle.
- R9: With unit 0's config bit 2 (range enable) set, unit 0 can hit only when unit 1's address-group term (enabled and address group matching) is true in the same sampled cycle.
- R10: The register map for each unit is: offset 0 = address value, 1 = address mask, 2 = data value, 3 = data mask, 4 = control value (8 bits), 5 = control mask (8 bits), 6 = config (4 bits). Unit 0 sits at addresses 0 to 6 and unit 1 at addresses 8 to 14. Bits above a register's width read as 0. Offset 7 and unit indices 2 and 3 read as 0 and ignore writes. cfg_rdata_o is 0 unless a read is being selected.
- R11: brk_o is 1 exactly when at least one bit of hit_o is 1. It is timed with hit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 32 | Observed bus address |
| bus_data_i | input | 32 | Observed bus data |
| bus_ctl_i | input | 8 | Observed control bits ([4:0] address group, [7:5] data group) |
| ext_cond_i | input | 2 | External condition, one bit per unit |
| cfg_sel_i | input | 1 | Register access strobe |
| cfg_wr_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | 5 | Register address {unit[1:0], offset[2:0]} |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data (combinational) |
| hit_o | output | 2 | Registered per-unit hit |
| range_o | output | 2 | Registered per-unit address-group term |
| brk_o | output | 1 | Registered break request |

## Verification
The assertions assume that every input has a known value from reset onward. They also assume that the register strobe, write bit and address are stable around each rising edge, and that the external condition lines are already synchronous to the clock. The stimulus meets these assumptions: it drives every input to a defined value at time zero, holds the strobe low during reset, and changes any input only one time unit after a rising edge. The chained and range assertions compare state from the previous cycle with present outputs, so they rely on reset having cleared the flag. For that reason the bench never enables chaining before reset is released.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   localparam int NUM_UNITS = 2;
   localparam int SEL_W     = 5;
   localparam int OFS_W     = 3;
   localparam int CFG_W     = 4;

   localparam int CFG_EN    = 0;
   localparam int CFG_CHAIN = 1;
   localparam int CFG_RANGE = 2;
   localparam int CFG_EXT   = 3;

   typedef enum logic [OFS_W-1:0] {
      RG_AVAL = 3'd0,
      RG_AMSK = 3'd1,
      RG_DVAL = 3'd2,
      RG_DMSK = 3'd3,
      RG_CVAL = 3'd4,
      RG_CMSK = 3'd5,
      RG_CFG  = 3'd6,
      RG_NONE = 3'd7
   } wpc_reg_e;

endpackage

// File: rtl/wpc_regfile.sv
module wpc_regfile
   import wpc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CTRL_W = 8,
   parameter int BUS_W  = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 sel_i,
   input  logic                                 wr_i,
   input  logic [SEL_W-1:0]                     addr_i,
   input  logic [BUS_W-1:0]                     wdata_i,
   output logic [BUS_W-1:0]                     rdata_o,
   output logic [NUM_UNITS-1:0][ADDR_W-1:0]     aval_o,
   output logic [NUM_UNITS-1:0][ADDR_W-1:0]     amsk_o,
   output logic [NUM_UNITS-1:0][DATA_W-1:0]     dval_o,
   output logic [NUM_UNITS-1:0][DATA_W-1:0]     dmsk_o,
   output logic [NUM_UNITS-1:0][CTRL_W-1:0]     cval_o,
   output logic [NUM_UNITS-1:0][CTRL_W-1:0]     cmsk_o,
   output logic [NUM_UNITS-1:0][CFG_W-1:0]      cfg_o,
   output logic [NUM_UNITS-1:0]                 cval_wr_o
);

   localparam int UIDX_W = SEL_W - OFS_W;

   logic [UIDX_W-1:0] unit_sel;
   wpc_reg_e          reg_sel;
   logic [NUM_UNITS-1:0][BUS_W-1:0] unit_rd;

   assign unit_sel = addr_i[SEL_W-1:OFS_W];
   assign reg_sel  = wpc_reg_e'(addr_i[OFS_W-1:0]);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic              we;
      logic [ADDR_W-1:0] aval_q, amsk_q;
      logic [DATA_W-1:0] dval_q, dmsk_q;
      logic [CTRL_W-1:0] cval_q, cmsk_q;
      logic [CFG_W-1:0]  cfg_q;

      assign we = sel_i && wr_i && (unit_sel == UIDX_W'(u));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            aval_q <= '0;
            amsk_q <= '0;
            dval_q <= '0;
            dmsk_q <= '0;
            cval_q <= '0;
            cmsk_q <= '0;
            cfg_q  <= '0;
         end else if (we) begin
            case (reg_sel)
               RG_AVAL: aval_q <= wdata_i[ADDR_W-1:0];
               RG_AMSK: amsk_q <= wdata_i[ADDR_W-1:0];
               RG_DVAL: dval_q <= wdata_i[DATA_W-1:0];
               RG_DMSK: dmsk_q <= wdata_i[DATA_W-1:0];
               RG_CVAL: cval_q <= wdata_i[CTRL_W-1:0];
               RG_CMSK: cmsk_q <= wdata_i[CTRL_W-1:0];
               RG_CFG:  cfg_q  <= wdata_i[CFG_W-1:0];
               default: ;
            endcase
         end
      end

      always_comb begin
         unit_rd[u] = '0;
         case (reg_sel)
            RG_AVAL: unit_rd[u] = BUS_W'(aval_q);
            RG_AMSK: unit_rd[u] = BUS_W'(amsk_q);
            RG_DVAL: unit_rd[u] = BUS_W'(dval_q);
            RG_DMSK: unit_rd[u] = BUS_W'(dmsk_q);
            RG_CVAL: unit_rd[u] = BUS_W'(cval_q);
            RG_CMSK: unit_rd[u] = BUS_W'(cmsk_q);
            RG_CFG:  unit_rd[u] = BUS_W'(cfg_q);
            default: unit_rd[u] = '0;
         endcase
      end

      assign aval_o[u]    = aval_q;
      assign amsk_o[u]    = amsk_q;
      assign dval_o[u]    = dval_q;
      assign dmsk_o[u]    = dmsk_q;
      assign cval_o[u]    = cval_q;
      assign cmsk_o[u]    = cmsk_q;
      assign cfg_o[u]     = cfg_q;
      assign cval_wr_o[u] = we && (reg_sel == RG_CVAL);
   end

   always_comb begin
      rdata_o = '0;
      if (sel_i && !wr_i) begin
         for (int u = 0; u < NUM_UNITS; u++) begin
            if (unit_sel == UIDX_W'(u)) rdata_o = unit_rd[u];
         end
      end
   end

   // R10: a write to a register that does not exist leaves every config field unchanged
   a_r10_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && wr_i && addr_i[OFS_W-1:0] == RG_NONE) |=> $stable(cfg_o));

endmodule

// File: rtl/wpc_unit.sv
module wpc_unit #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ACTL_W = 5,
   parameter int DCTL_W = 3
) (
   input  logic [ADDR_W-1:0]        a_val_i,
   input  logic [ADDR_W-1:0]        a_msk_i,
   input  logic [ADDR_W-1:0]        a_obs_i,
   input  logic [DATA_W-1:0]        d_val_i,
   input  logic [DATA_W-1:0]        d_msk_i,
   input  logic [DATA_W-1:0]        d_obs_i,
   input  logic [ACTL_W+DCTL_W-1:0] c_val_i,
   input  logic [ACTL_W+DCTL_W-1:0] c_msk_i,
   input  logic [ACTL_W+DCTL_W-1:0] c_obs_i,
   output logic                     addr_ok_o,
   output logic                     data_ok_o
);

   localparam int CTRL_W = ACTL_W + DCTL_W;
   localparam int AG_W   = ADDR_W + ACTL_W;

   logic [AG_W-1:0] ag_pass;

   assign ag_pass = ~({a_val_i, c_val_i[ACTL_W-1:0]} ^ {a_obs_i, c_obs_i[ACTL_W-1:0]})
                  |  {a_msk_i, c_msk_i[ACTL_W-1:0]};
   assign addr_ok_o = &ag_pass;

   if (DCTL_W > 0) begin : g_dctl
      localparam int DG_W = DATA_W + DCTL_W;
      logic [DG_W-1:0] dg_pass;
      assign dg_pass = ~({d_val_i, c_val_i[CTRL_W-1:ACTL_W]} ^ {d_obs_i, c_obs_i[CTRL_W-1:ACTL_W]})
                     |  {d_msk_i, c_msk_i[CTRL_W-1:ACTL_W]};
      assign data_ok_o = &dg_pass;
   end else begin : g_nodctl
      logic [DATA_W-1:0] dg_pass;
      assign dg_pass   = ~(d_val_i ^ d_obs_i) | d_msk_i;
      assign data_ok_o = &dg_pass;
   end

endmodule

// File: rtl/wpc_pair.sv
module wpc_pair
   import wpc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ACTL_W = 5,
   parameter int DCTL_W = 3,
   parameter int BUS_W  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr_i,
   input  logic [DATA_W-1:0]          bus_data_i,
   input  logic [ACTL_W+DCTL_W-1:0]   bus_ctl_i,
   input  logic [1:0]                 ext_cond_i,
   input  logic                       cfg_sel_i,
   input  logic                       cfg_wr_i,
   input  logic [4:0]                 cfg_addr_i,
   input  logic [BUS_W-1:0]           cfg_wdata_i,
   output logic [BUS_W-1:0]           cfg_rdata_o,
   output logic [1:0]                 hit_o,
   output logic [1:0]                 range_o,
   output logic                       brk_o
);

   localparam int CTRL_W = ACTL_W + DCTL_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= BUS_W) else $error("ADDR_W out of range");
      assert (DATA_W >= 1 && DATA_W <= BUS_W) else $error("DATA_W out of range");
      assert (ACTL_W >= 1 && CTRL_W <= BUS_W) else $error("control width out of range");
      assert (CFG_W <= BUS_W) else $error("config wider than bus");
   end

   logic [NUM_UNITS-1:0][ADDR_W-1:0] aval, amsk;
   logic [NUM_UNITS-1:0][DATA_W-1:0] dval, dmsk;
   logic [NUM_UNITS-1:0][CTRL_W-1:0] cval, cmsk;
   logic [NUM_UNITS-1:0][CFG_W-1:0]  cfg;
   logic [NUM_UNITS-1:0]             cval_wr;

   wpc_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .BUS_W(BUS_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (cfg_sel_i),
      .wr_i      (cfg_wr_i),
      .addr_i    (cfg_addr_i),
      .wdata_i   (cfg_wdata_i),
      .rdata_o   (cfg_rdata_o),
      .aval_o    (aval),
      .amsk_o    (amsk),
      .dval_o    (dval),
      .dmsk_o    (dmsk),
      .cval_o    (cval),
      .cmsk_o    (cmsk),
      .cfg_o     (cfg),
      .cval_wr_o (cval_wr)
   );

   logic [NUM_UNITS-1:0] term, rng, match;
   logic                 chain_q;
   logic [1:0]           hit_q, range_q;
   logic                 brk_q;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cmp
      logic aok, dok;
      wpc_unit #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACTL_W(ACTL_W), .DCTL_W(DCTL_W)
      ) i_unit (
         .a_val_i   (aval[u]),
         .a_msk_i   (amsk[u]),
         .a_obs_i   (bus_addr_i),
         .d_val_i   (dval[u]),
         .d_msk_i   (dmsk[u]),
         .d_obs_i   (bus_data_i),
         .c_val_i   (cval[u]),
         .c_msk_i   (cmsk[u]),
         .c_obs_i   (bus_ctl_i),
         .addr_ok_o (aok),
         .data_ok_o (dok)
      );
      assign rng[u]  = cfg[u][CFG_EN] && aok;
      assign term[u] = rng[u] && dok && (!cfg[u][CFG_EXT] || ext_cond_i[u]);

      // R6: a disabled unit raises neither output in the following cycle
      a_r6_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(cfg[u][CFG_EN]) |-> !hit_o[u] && !range_o[u]);
      // R4: a hit always comes with its address-group term
      a_r4_hit_has_range: assert property (@(posedge clk) disable iff (!rst_n)
         hit_o[u] |-> range_o[u]);
   end

   // unit 1 has no upstream partner; its gating bits are stored but unused
   logic unused_cfg1;
   assign unused_cfg1 = cfg[1][CFG_CHAIN] ^ cfg[1][CFG_RANGE];

   assign match[1] = term[1];
   assign match[0] = term[0]
                   && (!cfg[0][CFG_CHAIN] || chain_q)
                   && (!cfg[0][CFG_RANGE] || rng[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= 1'b0;
         hit_q   <= '0;
         range_q <= '0;
         brk_q   <= 1'b0;
      end else begin
         chain_q <= cval_wr[1] ? 1'b0 : (chain_q || match[1]);
         hit_q   <= match;
         range_q <= rng;
         brk_q   <= |match;
      end
   end

   assign hit_o   = hit_q;
   assign range_o = range_q;
   assign brk_o   = brk_q;

   // R7: a chained unit 0 hit needs the flag from before the sampled cycle
   a_r7_chain_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o[0] && $past(cfg[0][CFG_CHAIN])) |-> $past(chain_q));
   // R8: rewriting unit 1's control value empties the flag
   a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cval_wr[1]) |-> !chain_q);
   // R8: without that write the flag never falls
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(chain_q) && !$past(cval_wr[1])) |-> chain_q);
   // R9: a range-gated unit 0 hit needs unit 1's address term at the same time
   a_r9_range_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o[0] && $past(cfg[0][CFG_RANGE])) |-> range_o[1]);
   // R11: the break request follows the hits
   a_r11_brk_follows: assert property (@(posedge clk) disable iff (!rst_n)
      brk_o == (hit_o != 2'b00));

endmodule

// File: tb/test_wpc_pair.sv
module test_wpc_pair;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_data = '0;
   logic [7:0]  bus_ctl = '0;
   logic [1:0]  ext = '0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  ca = '0;
   logic [31:0] cw = '0;
   logic [31:0] crd;
   logic [1:0]  hit, rng;
   logic        brk;

   int checks = 0;
   int fails = 0;
   logic [31:0] m_reg [0:15];
   bit          m_chain;

   always #5 clk = ~clk;

   wpc_pair i_wpc_pair (
      .clk(clk), .rst_n(rst_n),
      .bus_addr_i(bus_addr), .bus_data_i(bus_data), .bus_ctl_i(bus_ctl),
      .ext_cond_i(ext),
      .cfg_sel_i(sel), .cfg_wr_i(wr), .cfg_addr_i(ca), .cfg_wdata_i(cw),
      .cfg_rdata_o(crd), .hit_o(hit), .range_o(rng), .brk_o(brk)
   );

   function automatic bit fld(logic [31:0] v, logic [31:0] m, logic [31:0] o, int w);
      for (int i = 0; i < w; i++)
         if (!m[i] && (v[i] !== o[i])) return 1'b0;
      return 1'b1;
   endfunction

   task automatic tick(string tag);
      bit [1:0] eh, er, t;
      bit       nchain;
      bit       aok, dok;
      logic [31:0] c;
      for (int u = 0; u < 2; u++) begin
         c   = m_reg[u*8+6];
         aok = fld(m_reg[u*8+0], m_reg[u*8+1], bus_addr, 32)
            && fld(m_reg[u*8+4], m_reg[u*8+5], {24'b0, bus_ctl}, 5);
         dok = fld(m_reg[u*8+2], m_reg[u*8+3], bus_data, 32)
            && fld(m_reg[u*8+4] >> 5, m_reg[u*8+5] >> 5, {29'b0, bus_ctl[7:5]}, 3);
         er[u] = c[0] && aok;
         t[u]  = er[u] && dok && (!c[3] || ext[u]);
      end
      eh[1] = t[1];
      eh[0] = t[0] && (!m_reg[6][1] || m_chain) && (!m_reg[6][2] || er[1]);
      nchain = (sel && wr && ca == 5'd12) ? 1'b0 : (m_chain || eh[1]);
      @(posedge clk);
      #1;
      if (sel && wr && ca[4] == 1'b0 && ca[2:0] != 3'd7) begin
         case (ca[2:0])
            3'd4, 3'd5: m_reg[ca[3:0]] = cw & 32'h0000_00FF;
            3'd6:       m_reg[ca[3:0]] = cw & 32'h0000_000F;
            default:    m_reg[ca[3:0]] = cw;
         endcase
      end
      m_chain = nchain;
      checks++;
      if (hit !== eh || rng !== er || brk !== (eh != 2'b00)) begin
         fails++;
         $display("FAIL %s: hit=%b range=%b brk=%b expected hit=%b range=%b brk=%b",
                  tag, hit, rng, brk, eh, er, (eh != 2'b00));
      end
   endtask

   task automatic wreg(logic [4:0] a, logic [31:0] d);
      sel = 1'b1; wr = 1'b1; ca = a; cw = d;
      tick("R10 write");
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rreg(logic [4:0] a, logic [31:0] exp, string tag);
      sel = 1'b1; wr = 1'b0; ca = a;
      #1;
      checks++;
      if (crd !== exp) begin
         fails++;
         $display("FAIL %s: read addr %0d got %h expected %h", tag, a, crd, exp);
      end
      sel = 1'b0;
      #1;
      checks++;
      if (crd !== 32'h0) begin
         fails++;
         $display("FAIL R10: idle read data %h expected 0", crd);
      end
   endtask

   task automatic bus(logic [31:0] a, logic [31:0] d, logic [7:0] c);
      bus_addr = a; bus_data = d; bus_ctl = c;
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      m_chain = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (hit !== 2'b00 || rng !== 2'b00 || brk !== 1'b0) begin
         fails++;
         $display("FAIL R1: during reset hit=%b range=%b brk=%b expected 0", hit, rng, brk);
      end
      rst_n = 1'b1;
      tick("R1");
      for (int i = 0; i < 16; i++) rreg(5'(i), 32'h0, "R1");

      // R10 register access
      wreg(5'd0, 32'h0000_1000);
      wreg(5'd4, 32'hFFFF_FF5A);
      wreg(5'd7, 32'hDEAD_BEEF);
      wreg(5'd16, 32'h1234_5678);
      wreg(5'd6, 32'hFFFF_FFF1);
      rreg(5'd4, 32'h0000_005A, "R10");
      rreg(5'd6, 32'h0000_0001, "R10");
      rreg(5'd7, 32'h0, "R10");
      rreg(5'd16, 32'h0, "R10");
      rreg(5'd0, 32'h0000_1000, "R10");

      // R2 exact compare
      bus(32'h0000_1000, 32'h0, 8'h5A);
      tick("R2"); tick("R2 R11");
      bus(32'h0000_1001, 32'h0, 8'h5A);
      tick("R2");
      // R3 masking
      wreg(5'd1, 32'h0000_00FF);
      bus(32'h0000_10A7, 32'h0, 8'h5A);
      tick("R3");
      bus(32'h0000_1100, 32'h0, 8'h5A);
      tick("R3");
      // R4 group split
      bus(32'h0000_1000, 32'h1, 8'h5A);
      tick("R4");
      bus(32'h0000_1000, 32'h0, 8'h1A);
      tick("R4");
      bus(32'h0000_1000, 32'h0, 8'h5E);
      tick("R4");
      bus(32'h0000_1000, 32'h0, 8'h5A);
      // R5 external condition
      wreg(5'd6, 32'h9);
      ext = 2'b00; tick("R5");
      ext = 2'b01; tick("R5");
      ext = 2'b00;
      // R6 disabled with everything masked
      wreg(5'd6, 32'h0);
      wreg(5'd1, 32'hFFFF_FFFF);
      wreg(5'd3, 32'hFFFF_FFFF);
      wreg(5'd5, 32'hFF);
      tick("R6"); tick("R6");
      // R7 chain
      wreg(5'd1, 32'h0);
      wreg(5'd3, 32'h0);
      wreg(5'd5, 32'h0);
      wreg(5'd6, 32'h3);
      tick("R7");
      wreg(5'd9, 32'hFFFF_FFFF);
      wreg(5'd11, 32'hFFFF_FFFF);
      wreg(5'd13, 32'hFF);
      wreg(5'd14, 32'h1);
      tick("R7"); tick("R7"); tick("R7");
      // R8 stickiness and clearing
      wreg(5'd14, 32'h0);
      tick("R8"); tick("R8");
      wreg(5'd12, 32'h0);
      tick("R8"); tick("R8");
      // R9 range gate
      wreg(5'd6, 32'h5);
      wreg(5'd1, 32'h0000_FFFF);
      wreg(5'd8, 32'h0000_2000);
      wreg(5'd9, 32'h0000_00FF);
      wreg(5'd14, 32'h1);
      bus(32'h0000_2010, 32'h0, 8'h5A);
      tick("R9");
      bus(32'h0000_3010, 32'h0, 8'h5A);
      tick("R9");
      bus(32'h0001_2010, 32'h0, 8'h5A);
      tick("R9");

      // mixed traffic
      wreg(5'd6, 32'h3);
      for (int n = 0; n < 400; n++) begin
         bus({16'h0, 3'b001, 5'($urandom), 8'($urandom)},
             ($urandom % 4 == 0) ? 32'h0 : 32'($urandom),
             ($urandom % 2 == 0) ? 8'h5A : 8'($urandom));
         ext = 2'($urandom);
         if ($urandom % 10 == 0) begin
            sel = 1'b1; wr = 1'b1;
            ca = ($urandom % 2 == 0) ? 5'd12 : 5'(($urandom % 2) * 8 + 1);
            cw = 32'($urandom);
            tick("R8 R2 mixed");
            sel = 1'b0; wr = 1'b0;
         end else begin
            tick("R2 mixed");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule